// File: doc/BRIEF.md
# Latency-Tolerant Convolution Stage

This block convolves one grayscale feature map of signed fixed-point pixels with a bank of small square kernels. It produces one output plane per kernel and keeps the image size, padding the border with zeros. It pulls pixels from a synchronous read port whose latency is a parameter. It stores every result into an output memory at an address from a counter, laid out plane by plane, then row by row, then column by column. Kernel weights and per-plane biases are constants computed inside the block.

A one-cycle `start` pulse launches a run. The block then owns both memories until it pulses `done`. Tap addresses are issued one per cycle, in the order plane, output row, output column, kernel row, kernel column. A tag travels beside each read through a delay line as deep as the memory latency. The returning word is therefore always paired with the weight of the tap that fetched it, whatever the latency.

Top module: `conv_stage`

## Requirements
- R1: After reset, `busy`, `done`, `rd_en` and `wr_en` are all low.
- R2: A `start` pulse while idle makes `busy` high on the next cycle. `busy` stays high until `done`, and `done` is high for exactly one cycle with `busy` already low in that cycle.
- R3: A `start` pulse while `busy` is high has no effect: the run's writes, their count and the single `done` pulse are unchanged.
- R4: Padding keeps each output plane IMG_H×IMG_W. A kernel tap that falls outside the image contributes zero and issues no read, so the number of reads per run equals N_OUT times the number of in-image taps, and every `rd_addr` is below IMG_H*IMG_W (pixel (y,x) lives at y*IMG_W+x).
- R5: For a read issued with `rd_en` high in some cycle, `rd_data` is sampled RD_LAT cycles later. The results are correct for that latency, with no mixing of words from different taps.
- R6: Each result is acc>>>W_FRAC saturated to DATA_W bits, where acc = bias(ch)·2^W_FRAC + Σ pixel·w(ch,kr,kc). The weight is w = (((5·ch + 3·kr + 7·kc + 1) mod 17) − 8)·8 and the bias is bias = ((29·ch + 3) mod 61) − 30, both raw integers. The kernel center sits at offset K/2.
- R7: Saturation clamps to +2^(DATA_W−1)−1 and to −2^(DATA_W−1) for sums beyond either end.
- R8: Writes come in order, and the k-th write of a run has address k = ch·IMG_H·IMG_W + row·IMG_W + col.
- R9: Each of the N_OUT·IMG_H·IMG_W locations is written exactly once per run. No write or read occurs while `busy` is low, and none occurs after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle launch pulse |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Input memory read strobe |
| rd_addr | output | $clog2(IMG_H*IMG_W) | Input pixel address |
| rd_data | input | DATA_W | Pixel returned RD_LAT cycles after the read |
| wr_en | output | 1 | Output memory write strobe |
| wr_addr | output | $clog2(N_OUT*IMG_H*IMG_W) | Output address, plane-row-column order |
| wr_data | output | DATA_W | Saturated result |

## Verification
`busy` is due one cycle after the `start` edge. A pixel is consumed RD_LAT cycles after its read strobe, and a result's write strobe appears on the edge that consumes its final tap. `done` follows one cycle after the final write. The bench models the memory as a delay line of RD_LAT registers and feeds the strobe back as the design would see it. It samples every output on the falling edge, so each check lands mid-cycle in the cycle where the result is due. Expected results are queued in write order, and the monitor compares each write strobe against the head of the queue, so an early, late, extra or missing write shows up as a miscompare.

// File: rtl/conv_stage_pkg.sv
package conv_stage_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } run_state_e;

   // Raw integer kernel weight for plane ch, kernel row kr, kernel column kc.
   function automatic int kernel_weight(input int ch, input int kr, input int kc);
      return (((ch * 5 + kr * 3 + kc * 7 + 1) % 17) - 8) * 8;
   endfunction

   // Raw bias in pixel format for plane ch.
   function automatic int plane_bias(input int ch);
      return ((ch * 29 + 3) % 61) - 30;
   endfunction

endpackage

// File: rtl/conv_tap_issuer.sv
module conv_tap_issuer #(
   parameter int IMG_H  = 28,
   parameter int IMG_W  = 28,
   parameter int KSIZE  = 3,
   parameter int N_OUT  = 32,
   parameter int AW_IN  = $clog2(IMG_H * IMG_W),
   parameter int CH_W   = (N_OUT > 1) ? $clog2(N_OUT) : 1,
   parameter int KI_W   = (KSIZE > 1) ? $clog2(KSIZE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   output logic              rd_en,
   output logic [AW_IN-1:0]  rd_addr,
   output logic              t_vld,
   output logic              t_first,
   output logic              t_last,
   output logic              t_pad,
   output logic [CH_W-1:0]   t_ch,
   output logic [KI_W-1:0]   t_kr,
   output logic [KI_W-1:0]   t_kc
);
   localparam int PAD = KSIZE / 2;
   localparam int RW  = (IMG_H > 1) ? $clog2(IMG_H) : 1;
   localparam int CW  = (IMG_W > 1) ? $clog2(IMG_W) : 1;

   logic            issuing_q;
   logic [CH_W-1:0] ch_q;
   logic [RW-1:0]   row_q;
   logic [CW-1:0]   col_q;
   logic [KI_W-1:0] kr_q, kc_q;

   logic            outside;
   logic [AW_IN-1:0] addr_c;
   logic            end_kc, end_kr, end_col, end_row, end_ch;

   always_comb begin
      int iy, ix;
      iy      = int'(row_q) + int'(kr_q) - PAD;
      ix      = int'(col_q) + int'(kc_q) - PAD;
      outside = (iy < 0) || (iy >= IMG_H) || (ix < 0) || (ix >= IMG_W);
      addr_c  = outside ? '0 : AW_IN'(iy * IMG_W + ix);
   end

   assign end_kc  = (int'(kc_q)  == KSIZE - 1);
   assign end_kr  = (int'(kr_q)  == KSIZE - 1);
   assign end_col = (int'(col_q) == IMG_W - 1);
   assign end_row = (int'(row_q) == IMG_H - 1);
   assign end_ch  = (int'(ch_q)  == N_OUT - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issuing_q <= 1'b0;
         ch_q      <= '0;
         row_q     <= '0;
         col_q     <= '0;
         kr_q      <= '0;
         kc_q      <= '0;
      end else if (go) begin
         issuing_q <= 1'b1;
         ch_q      <= '0;
         row_q     <= '0;
         col_q     <= '0;
         kr_q      <= '0;
         kc_q      <= '0;
      end else if (issuing_q) begin
         if (!end_kc) begin
            kc_q <= kc_q + 1'b1;
         end else begin
            kc_q <= '0;
            if (!end_kr) begin
               kr_q <= kr_q + 1'b1;
            end else begin
               kr_q <= '0;
               if (!end_col) begin
                  col_q <= col_q + 1'b1;
               end else begin
                  col_q <= '0;
                  if (!end_row) begin
                     row_q <= row_q + 1'b1;
                  end else begin
                     row_q <= '0;
                     if (!end_ch) ch_q <= ch_q + 1'b1;
                     else         issuing_q <= 1'b0;
                  end
               end
            end
         end
      end
   end

   // Issue register: read strobe plus the tag that travels with it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_en   <= 1'b0;
         rd_addr <= '0;
         t_vld   <= 1'b0;
         t_first <= 1'b0;
         t_last  <= 1'b0;
         t_pad   <= 1'b0;
         t_ch    <= '0;
         t_kr    <= '0;
         t_kc    <= '0;
      end else begin
         rd_en   <= issuing_q && !outside;
         rd_addr <= addr_c;
         t_vld   <= issuing_q;
         t_first <= (kr_q == '0) && (kc_q == '0);
         t_last  <= end_kr && end_kc;
         t_pad   <= outside;
         t_ch    <= ch_q;
         t_kr    <= kr_q;
         t_kc    <= kc_q;
      end
   end
endmodule

// File: rtl/conv_tag_delay.sv
module conv_tag_delay #(
   parameter int TAG_W = 8,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [TAG_W-1:0] in_tag,
   output logic             out_vld,
   output logic [TAG_W-1:0] out_tag
);
   generate
      if (DEPTH == 0) begin : g_pass
         assign out_vld = in_vld;
         assign out_tag = in_tag;
      end else begin : g_chain
         logic             vld_q [DEPTH];
         logic [TAG_W-1:0] tag_q [DEPTH];
         for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  vld_q[s] <= 1'b0;
                  tag_q[s] <= '0;
               end else if (s == 0) begin
                  vld_q[s] <= in_vld;
                  tag_q[s] <= in_tag;
               end else begin
                  vld_q[s] <= vld_q[(s == 0) ? 0 : s - 1];
                  tag_q[s] <= tag_q[(s == 0) ? 0 : s - 1];
               end
            end
         end
         assign out_vld = vld_q[DEPTH-1];
         assign out_tag = tag_q[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/conv_mac_writer.sv
module conv_mac_writer
   import conv_stage_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int WGT_W  = 8,
   parameter int W_FRAC = 6,
   parameter int ACC_W  = 30,
   parameter int CH_W   = 5,
   parameter int KI_W   = 2,
   parameter int AW_OUT = 15
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     vld,
   input  logic                     first,
   input  logic                     last,
   input  logic                     pad,
   input  logic [CH_W-1:0]          ch,
   input  logic [KI_W-1:0]          kr,
   input  logic [KI_W-1:0]          kc,
   input  logic [DATA_W-1:0]        pix_in,
   output logic                     wr_en,
   output logic [AW_OUT-1:0]        wr_addr,
   output logic [DATA_W-1:0]        wr_data
);
   localparam int SAT_HI_I = (2 ** (DATA_W - 1)) - 1;
   localparam int SAT_LO_I = -(2 ** (DATA_W - 1));
   localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(SAT_HI_I);
   localparam logic signed [ACC_W-1:0] SAT_LO = ACC_W'(SAT_LO_I);

   logic signed [DATA_W-1:0]       pix;
   logic signed [WGT_W-1:0]        wgt;
   logic signed [DATA_W+WGT_W-1:0] prod;
   logic signed [ACC_W-1:0]        bias_acc, base, sum, scaled, acc_q;
   logic signed [DATA_W-1:0]       clamped;
   logic [AW_OUT-1:0]              cnt_q;

   assign pix      = pad ? '0 : $signed(pix_in);
   assign wgt      = WGT_W'(kernel_weight(int'(ch), int'(kr), int'(kc)));
   assign prod     = pix * wgt;
   assign bias_acc = ACC_W'(plane_bias(int'(ch)) * (2 ** W_FRAC));
   assign base     = first ? bias_acc : acc_q;
   assign sum      = base + ACC_W'(prod);
   assign scaled   = sum >>> W_FRAC;

   always_comb begin
      if (scaled > SAT_HI)      clamped = DATA_W'(SAT_HI_I);
      else if (scaled < SAT_LO) clamped = DATA_W'(SAT_LO_I);
      else                      clamped = DATA_W'(scaled);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         cnt_q   <= '0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (clr) cnt_q <= '0;
         if (vld) begin
            acc_q <= sum;
            if (last) begin
               wr_en   <= 1'b1;
               wr_addr <= cnt_q;
               wr_data <= clamped;
               cnt_q   <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/conv_stage.sv
module conv_stage
   import conv_stage_pkg::*;
#(
   parameter int IMG_H  = 28,
   parameter int IMG_W  = 28,
   parameter int KSIZE  = 3,
   parameter int N_OUT  = 32,
   parameter int DATA_W = 16,
   parameter int FRAC_W = 7,
   parameter int WGT_W  = 8,
   parameter int W_FRAC = 6,
   parameter int RD_LAT = 2,
   localparam int AW_IN  = $clog2(IMG_H * IMG_W),
   localparam int AW_OUT = $clog2(N_OUT * IMG_H * IMG_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              rd_en,
   output logic [AW_IN-1:0]  rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [AW_OUT-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   localparam int CH_W     = (N_OUT > 1) ? $clog2(N_OUT) : 1;
   localparam int KI_W     = (KSIZE > 1) ? $clog2(KSIZE) : 1;
   localparam int ACC_W    = DATA_W + WGT_W + $clog2(KSIZE * KSIZE) + 2;
   localparam int TAG_W    = 3 + CH_W + 2 * KI_W;
   localparam int LAST_OUT = N_OUT * IMG_H * IMG_W - 1;

   generate
      if (RD_LAT < 1)            begin : g_bad_lat   $error("RD_LAT must be at least 1"); end
      if (KSIZE % 2 == 0)        begin : g_bad_k     $error("KSIZE must be odd"); end
      if (FRAC_W >= DATA_W)      begin : g_bad_frac  $error("FRAC_W must be below DATA_W"); end
      if (W_FRAC >= WGT_W + 8)   begin : g_bad_wfrac $error("W_FRAC too large"); end
      if (N_OUT < 1)             begin : g_bad_n     $error("N_OUT must be positive"); end
   endgenerate

   run_state_e state_q;
   logic       go, fin;

   assign go   = start && (state_q == ST_IDLE);
   assign fin  = wr_en && (int'(wr_addr) == LAST_OUT);
   assign busy = (state_q == ST_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done    <= 1'b0;
      end else begin
         done <= fin;
         if (go)       state_q <= ST_RUN;
         else if (fin) state_q <= ST_IDLE;
      end
   end

   logic            i_vld, i_first, i_last, i_pad;
   logic [CH_W-1:0] i_ch;
   logic [KI_W-1:0] i_kr, i_kc;

   conv_tap_issuer #(
      .IMG_H(IMG_H), .IMG_W(IMG_W), .KSIZE(KSIZE), .N_OUT(N_OUT),
      .AW_IN(AW_IN), .CH_W(CH_W), .KI_W(KI_W)
   ) i_issuer (
      .clk(clk), .rst_n(rst_n), .go(go),
      .rd_en(rd_en), .rd_addr(rd_addr),
      .t_vld(i_vld), .t_first(i_first), .t_last(i_last), .t_pad(i_pad),
      .t_ch(i_ch), .t_kr(i_kr), .t_kc(i_kc)
   );

   logic             d_vld;
   logic [TAG_W-1:0] d_tag;

   conv_tag_delay #(.TAG_W(TAG_W), .DEPTH(RD_LAT)) i_delay (
      .clk(clk), .rst_n(rst_n),
      .in_vld(i_vld),
      .in_tag({i_first, i_last, i_pad, i_ch, i_kr, i_kc}),
      .out_vld(d_vld), .out_tag(d_tag)
   );

   logic            d_first, d_last, d_pad;
   logic [CH_W-1:0] d_ch;
   logic [KI_W-1:0] d_kr, d_kc;

   assign {d_first, d_last, d_pad, d_ch, d_kr, d_kc} = d_tag;

   conv_mac_writer #(
      .DATA_W(DATA_W), .WGT_W(WGT_W), .W_FRAC(W_FRAC), .ACC_W(ACC_W),
      .CH_W(CH_W), .KI_W(KI_W), .AW_OUT(AW_OUT)
   ) i_mac (
      .clk(clk), .rst_n(rst_n), .clr(go),
      .vld(d_vld), .first(d_first), .last(d_last), .pad(d_pad),
      .ch(d_ch), .kr(d_kr), .kc(d_kc), .pix_in(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );
endmodule

// File: rtl/conv_stage_chk.sv
module conv_stage_chk #(
   parameter int IMG_H  = 28,
   parameter int IMG_W  = 28,
   parameter int N_OUT  = 32,
   parameter int AW_IN  = 10,
   parameter int AW_OUT = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              rd_en,
   input logic [AW_IN-1:0]  rd_addr,
   input logic              wr_en,
   input logic [AW_OUT-1:0] wr_addr
);
   localparam int TOTAL = N_OUT * IMG_H * IMG_W;

   logic [AW_OUT:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                seen_q <= '0;
      else if (start && !busy)   seen_q <= '0;
      else if (wr_en)            seen_q <= seen_q + 1'b1;
   end

   AST_START_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) start && !busy |=> busy);              // R2
   AST_DONE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                      // R2
   AST_DONE_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);                      // R2
   AST_BUSY_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) busy && !$past(done) && start |=> busy || done); // R3
   AST_RD_RANGE:      assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> int'(rd_addr) < IMG_H * IMG_W); // R4
   AST_RD_OWNED:      assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> busy);                     // R9
   AST_WR_OWNED:      assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> busy);                     // R9
   AST_WR_SEQUENCE:   assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> wr_addr == AW_OUT'(seen_q)); // R8
   AST_WR_COMPLETE:   assert property (@(posedge clk) disable iff (!rst_n) done |-> int'(seen_q) == TOTAL);     // R9
endmodule

bind conv_stage conv_stage_chk #(
   .IMG_H(IMG_H), .IMG_W(IMG_W), .N_OUT(N_OUT), .AW_IN(AW_IN), .AW_OUT(AW_OUT)
) i_conv_stage_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/test_conv_stage.sv
module test_conv_stage;
   localparam int CLK_PERIOD = 10;
   localparam int H   = 6;
   localparam int W   = 7;
   localparam int K   = 3;
   localparam int NO  = 3;
   localparam int DW  = 16;
   localparam int WF  = 2;
   localparam int RDL = 3;
   localparam int AWI = $clog2(H * W);
   localparam int AWO = $clog2(NO * H * W);
   localparam int NPIX = H * W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic busy, done, rd_en, wr_en;
   logic [AWI-1:0] rd_addr;
   logic [DW-1:0]  rd_data;
   logic [AWO-1:0] wr_addr;
   logic [DW-1:0]  wr_data;

   always #(CLK_PERIOD / 2) clk = ~clk;

   conv_stage #(
      .IMG_H(H), .IMG_W(W), .KSIZE(K), .N_OUT(NO), .DATA_W(DW),
      .FRAC_W(7), .WGT_W(8), .W_FRAC(WF), .RD_LAT(RDL)
   ) i_conv_stage (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   // Input memory: RDL registers between the strobe and the data.
   int img [NPIX];
   logic [DW-1:0] mpipe [RDL];
   always @(posedge clk) begin
      mpipe[0] <= rd_en ? DW'(img[int'(rd_addr) % NPIX]) : 16'hDEAD;
      for (int i = 1; i < RDL; i++) mpipe[i] <= mpipe[i-1];
   end
   assign rd_data = mpipe[RDL-1];

   int checks = 0;
   int fails  = 0;
   int nwr = 0;
   int nrd = 0;
   string cur_req = "R6";

   typedef struct { int addr; int data; } exp_t;
   exp_t expq [$];

   function automatic int ref_w(int ch, int kr, int kc);
      return (((5 * ch + 3 * kr + 7 * kc + 1) % 17) - 8) * 8;
   endfunction

   function automatic int ref_b(int ch);
      return ((29 * ch + 3) % 61) - 30;
   endfunction

   function automatic int golden(int ch, int r, int c);
      longint acc;
      acc = longint'(ref_b(ch)) * (longint'(1) << WF);
      for (int kr = 0; kr < K; kr++)
         for (int kc = 0; kc < K; kc++) begin
            int iy, ix;
            iy = r + kr - K / 2;
            ix = c + kc - K / 2;
            if (iy >= 0 && iy < H && ix >= 0 && ix < W)
               acc += longint'(img[iy * W + ix]) * longint'(ref_w(ch, kr, kc));
         end
      acc = acc >>> WF;
      if (acc > 32767)  acc = 32767;
      if (acc < -32768) acc = -32768;
      return int'(acc);
   endfunction

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Monitor: pops expected results as write strobes appear.
   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         nwr++;
         if (expq.size() == 0) begin
            check(1'b0, "R9", "unexpected write addr", int'(wr_addr), -1);
         end else begin
            exp_t e;
            e = expq.pop_front();
            check(int'(wr_addr) == e.addr, "R8", "write address", int'(wr_addr), e.addr);
            check(int'($signed(wr_data)) == e.data, cur_req, "write data",
                  int'($signed(wr_data)), e.data);
         end
      end
      if (rst_n && rd_en) begin
         nrd++;
         if (int'(rd_addr) >= NPIX) check(1'b0, "R4", "read address", int'(rd_addr), NPIX - 1);
      end
   end

   task automatic run_image(input int pat, input string req, input bit poke);
      int exp_rd, cyc, ndone;
      for (int i = 0; i < NPIX; i++) begin
         case (pat)
            0:       img[i] = ((i * 997) % 4001) - 2000;
            1:       img[i] = ((i * 7919 + 13) % 65536) - 32768;
            2:       img[i] = 32767;
            default: img[i] = -32768;
         endcase
      end
      exp_rd = 0;
      for (int ch = 0; ch < NO; ch++)
         for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
               exp_t e;
               e.addr = ch * NPIX + r * W + c;
               e.data = golden(ch, r, c);
               expq.push_back(e);
               for (int kr = 0; kr < K; kr++)
                  for (int kc = 0; kc < K; kc++)
                     if (r + kr - 1 >= 0 && r + kr - 1 < H && c + kc - 1 >= 0 && c + kc - 1 < W)
                        exp_rd++;
            end
      cur_req = req;
      nwr = 0;
      nrd = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
      cyc = 0;
      ndone = 0;
      while (!done && cyc < 20000) begin
         if (!busy) check(1'b0, "R2", "busy dropped early", int'(busy), 1);
         start = (poke && cyc == 40) ? 1'b1 : 1'b0;   // R3 stimulus
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      check(done == 1'b1, "R2", "done seen", int'(done), 1);
      check(busy == 1'b0, "R2", "busy low with done", int'(busy), 0);
      @(negedge clk);
      check(done == 1'b0, "R2", "done one cycle", int'(done), 0);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (done) ndone++;
      end
      check(ndone == 0, poke ? "R3" : "R9", "extra done pulses", ndone, 0);
      check(nwr == NO * NPIX, poke ? "R3" : "R9", "write count", nwr, NO * NPIX);
      check(nrd == exp_rd, "R4", "read count", nrd, exp_rd);
      check(expq.size() == 0, "R9", "results left over", expq.size(), 0);
      check(busy == 1'b0 && !wr_en && !rd_en, "R9", "quiet after done", int'(busy), 0);
      expq.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
      check(done == 1'b0, "R1", "done in reset", int'(done), 0);
      check(rd_en == 1'b0 && wr_en == 1'b0, "R1", "strobes in reset", int'(rd_en | wr_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0, "R1", "idle after reset", int'(busy), 0);
      run_image(0, "R5", 1'b0);   // ramp image, latency pairing
      run_image(1, "R6", 1'b0);   // scattered full-range image
      run_image(2, "R7", 1'b1);   // positive extreme with a start during the run
      run_image(3, "R7", 1'b0);   // negative extreme
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule